// File: doc/BRIEF.md
# Chop-Aware Conversion Rate Timer

This block sets the output-update cadence of a decimating converter. It counts modulator clock enables and issues a one-cycle result-ready strobe each time a conversion period has elapsed. The length of a period, in modulator enables, comes from the filter word. It is eight times the word when chopping is off and twenty-four times the word when chopping is on. A word below the smallest legal value for the active chop mode is raised to that minimum.

The filter word and chop flag are captured when a period begins. Writes that arrive during a period take effect only at the next period. A synchronous restart from the mode controller discards the partial count and begins a fresh period from the current settings. A busy flag is high from reset or restart until the first result of that run, so the controller can tell whether the filter has produced an output since it was last restarted.

Top module: `conv_rate_timer`

## Requirements
- R1: After reset, ready is 0 and busy is 1. The first period uses the reset filter word 69 with chopping off, so it lasts 552 enables whatever the inputs are.
- R2: With chop_en = 0, a period lasts 8 × sf_word modulator enables.
- R3: With chop_en = 1, a period lasts 24 × sf_word modulator enables.
- R4: A word below the minimum is clamped to it. The minimum is 3 with chopping off, giving 24 enables, and 13 with chopping on, giving 312 enables.
- R5: The largest word, 255 with chopping on, gives a 6120-enable period.
- R6: Only cycles with mod_en = 1 advance the count. Cycles without an enable do not lengthen or shorten the period in enables.
- R7: sf_word and chop_en are sampled at the start of a period. A change made during a period leaves that period's length unchanged.
- R8: ready is high for exactly one clock. It rises in the clock after the edge at which the final enable of a period is counted.
- R9: restart clears the count and starts a new period from the current sf_word and chop_en. An enable in the restart cycle is not counted.
- R10: When restart coincides with the final enable of a period, no strobe is issued.
- R11: busy goes to 1 on restart. It stays 1 until the first strobe and is 0 in the cycle that strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Modulator clock enable, one system clock wide |
| sf_word | input | 8 | Filter (decimation) word |
| chop_en | input | 1 | 1 = chopping enabled |
| restart | input | 1 | Synchronous restart from the mode controller |
| ready | output | 1 | One-cycle result-ready strobe |
| busy | output | 1 | No result yet since reset or restart |

## Verification
Restart and the end of a period can fall on the same edge. The bench provokes this by counting enables from a strobe and raising restart exactly on the enable that would complete the period. It judges the outcome by the absence of a strobe in the following clock, by busy being set again, and by the next strobe arriving one full fresh period after the restart. The scoreboard would flag any strobe that escaped as unexpected.

// File: rtl/conv_timer_pkg.sv
package conv_timer_pkg;
  localparam int SF_W         = 8;
  localparam int PLAIN_MULT   = 8;
  localparam int CHOP_MULT    = 24;
  localparam int MIN_SF_PLAIN = 3;
  localparam int MIN_SF_CHOP  = 13;
  localparam int RESET_SF     = 69;
  localparam int MAX_PERIOD   = CHOP_MULT * ((1 << SF_W) - 1);
  localparam int CNT_W        = $clog2(MAX_PERIOD + 1);

  typedef logic [CNT_W-1:0] period_t;

  // Period length in modulator enables for a word and chop setting.
  function automatic period_t period_of(input int sf, input logic chop);
    int eff;
    int lo;
    lo  = chop ? MIN_SF_CHOP : MIN_SF_PLAIN;
    eff = (sf < lo) ? lo : sf;
    return period_t'(eff * (chop ? CHOP_MULT : PLAIN_MULT));
  endfunction
endpackage

// File: rtl/cr_period_calc.sv
module cr_period_calc
  import conv_timer_pkg::*;
(
  input  logic [SF_W-1:0] sf_word,
  input  logic            chop_en,
  output period_t         period
);
  localparam logic [SF_W-1:0] LO_PLAIN = SF_W'(MIN_SF_PLAIN);
  localparam logic [SF_W-1:0] LO_CHOP  = SF_W'(MIN_SF_CHOP);

  logic [SF_W-1:0] floor_w;
  logic [SF_W-1:0] eff_w;

  always_comb begin
    floor_w = chop_en ? LO_CHOP : LO_PLAIN;
    eff_w   = (sf_word < floor_w) ? floor_w : sf_word;
    if (chop_en) period = period_t'(eff_w) * period_t'(CHOP_MULT);
    else         period = period_t'(eff_w) * period_t'(PLAIN_MULT);
  end
endmodule

// File: rtl/cr_counter.sv
module cr_counter
  import conv_timer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    mod_en,
  input  logic    restart,
  input  period_t next_period,
  output logic    finish,
  output logic    ready
);
  localparam period_t RESET_PERIOD = period_of(RESET_SF, 1'b0);
  localparam period_t SMALLEST     = period_t'(PLAIN_MULT * MIN_SF_PLAIN);
  localparam period_t LARGEST      = period_t'(MAX_PERIOD);

  period_t cnt_q;
  period_t per_q;
  logic    last_cnt;

  assign last_cnt = (cnt_q == per_q - 1'b1);
  assign finish   = mod_en && last_cnt && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= RESET_PERIOD;
      ready <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      per_q <= next_period;
      ready <= 1'b0;
    end else begin
      ready <= finish;
      if (mod_en) begin
        if (last_cnt) begin
          cnt_q <= '0;
          per_q <= next_period;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8
  ready_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  // R10
  restart_kills_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> !ready);
  // R6
  hold_without_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mod_en && !restart) |=> (cnt_q == $past(cnt_q)));
  // R4
  period_floor_chk: assert property (@(posedge clk) disable iff (rst)
    per_q >= SMALLEST);
  // R5
  period_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    per_q <= LARGEST);
  // R8
  count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < per_q);
endmodule

// File: rtl/conv_rate_timer.sv
module conv_rate_timer
  import conv_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            mod_en,
  input  logic [SF_W-1:0] sf_word,
  input  logic            chop_en,
  input  logic            restart,
  output logic            ready,
  output logic            busy
);
  period_t next_period;
  logic    finish;

  cr_period_calc u_calc (
    .sf_word (sf_word),
    .chop_en (chop_en),
    .period  (next_period)
  );

  cr_counter u_count (
    .clk         (clk),
    .rst         (rst),
    .mod_en      (mod_en),
    .restart     (restart),
    .next_period (next_period),
    .finish      (finish),
    .ready       (ready)
  );

  always_ff @(posedge clk) begin
    if (rst || restart) busy <= 1'b1;
    else if (finish)    busy <= 1'b0;
  end

  // R11
  busy_clear_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> !busy);
  // R11
  busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(restart));
endmodule

// File: tb/conv_rate_timer_bench.sv
module conv_rate_timer_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct { int len; string tag; } item_t;

  logic       clk = 0;
  logic       rst = 1;
  logic       mod_en = 0;
  logic [7:0] sf_word = 8'd10;
  logic       chop_en = 0;
  logic       restart = 0;
  logic       ready;
  logic       busy;

  int    checks = 0;
  int    errors = 0;
  int    en_div = 1;
  int    phase = 0;
  int    en_cnt = 0;
  logic  prev_ready = 0;
  item_t expq[$];

  conv_rate_timer u_conv_rate_timer (
    .clk(clk), .rst(rst), .mod_en(mod_en), .sf_word(sf_word),
    .chop_en(chop_en), .restart(restart), .ready(ready), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // enable generator
  always @(negedge clk) begin
    if (en_div <= 1) mod_en <= 1'b1;
    else begin
      phase = (phase + 1 >= en_div) ? 0 : phase + 1;
      mod_en <= (phase == 0);
    end
  end

  // enables counted since the current period began
  always @(posedge clk) begin
    if (rst || restart) en_cnt <= 0;
    else if (ready)     en_cnt <= mod_en ? 1 : 0;
    else if (mod_en)    en_cnt <= en_cnt + 1;
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (ready) begin
        if (prev_ready) check("R8 strobe width", 2, 1);
        if (expq.size() == 0) check("R10 unexpected strobe", 1, 0);
        else begin
          item_t it;
          it = expq.pop_front();
          check({it.tag, " period"}, en_cnt, it.len);
          check("R11 busy at strobe", busy, 0);
        end
      end
      prev_ready = ready;
    end
  end

  task automatic expect_period(input int len, input string tag);
    item_t it;
    it.len = len;
    it.tag = tag;
    expq.push_back(it);
    wait (expq.size() == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 ready after reset", ready, 0);
    check("R1 busy after reset", busy, 1);
    expect_period(552, "R1");
    expect_period(80, "R2");
    expect_period(80, "R2");
    sf_word = 8'd2;
    expect_period(80, "R7");
    expect_period(24, "R4");
    sf_word = 8'd5; chop_en = 1;
    expect_period(24, "R7");
    expect_period(312, "R4");
    sf_word = 8'd69;
    expect_period(312, "R7");
    expect_period(1656, "R3");
    sf_word = 8'd255;
    expect_period(1656, "R3");
    expect_period(6120, "R5");
    sf_word = 8'd3; chop_en = 0; en_div = 3;
    expect_period(6120, "R7");
    expect_period(24, "R6");
    expect_period(24, "R6");
    en_div = 1;
    expect_period(24, "R2");
    // collision: restart on the final enable of a 24-enable period
    repeat (23) @(negedge clk);
    restart = 1;
    @(negedge clk);
    restart = 0;
    check("R10 no strobe on collision", ready, 0);
    check("R11 busy after restart", busy, 1);
    expect_period(24, "R9");
    // restart in mid-period reloads current settings
    sf_word = 8'd20;
    repeat (10) @(negedge clk);
    restart = 1;
    @(negedge clk);
    restart = 0;
    check("R9 busy after restart", busy, 1);
    check("R9 no strobe after restart", ready, 0);
    expect_period(160, "R9");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule